// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fetch Fault

This block sits between the instruction fetch port and the decode stage. Every fetch response is a 16-bit word plus a bus-error flag. The block keeps each word in a small circular queue with its error flag beside it, as a tag, and hands words to decode in program order. When the fetch response arrives, the error flag raises nothing. A fault is reported only when decode consumes a tagged word. That word may be the opword of an instruction or one of its extension words. If a change of flow discards the tagged word first, the fault disappears with it.

Decode looks at the head word on `peek_word`. It then asks to take an instruction by raising `dec_take` and giving its number of extension words on `dec_ext`. The block issues the instruction only when every one of its words is in the queue. The issue appears one cycle later on the `inst_*` outputs. A clean instruction gets a commit strobe. An instruction that contains a tagged word gets an abort strobe instead, together with an access-error request to the exception logic. The request carries vector 2 and the address of the instruction's opword. A flush from execute empties the queue in one cycle and reloads the opword address. It also toggles a one-bit epoch, and fetch responses that still carry the old epoch are dropped. The queue depth must be a power of two and at least one word larger than the longest instruction.

Top module: `pfq_deferred_fault`

## Requirements
- R1: After reset the queue is empty (`avail` = 0, `peek_valid` = 0), `rsp_ready` = 1, `cur_epoch` = 0, and `inst_valid`, `inst_commit`, `inst_abort` and `exc_req` are all 0.
- R2: A response is accepted when `rsp_valid` = 1, `rsp_epoch` = `cur_epoch` and `rsp_ready` = 1. Accepted words leave in arrival order. `peek_word` shows the oldest word. An issued instruction shows its opword on `inst_opword` and extension word k on `inst_ext[16k+15:16k]`.
- R3: Accepting a response with `rsp_err` = 1 raises nothing. `exc_req` is 1 only in the cycle after an instruction was issued.
- R4: If the opword of an issued instruction is tagged, then in the cycle after the take `inst_abort` = 1, `exc_req` = 1, `exc_vector` = 2 and `exc_addr` = `inst_pc`.
- R5: If any extension word of an issued instruction is tagged and its opword is clean, the result is the same abort and access-error request as in R4.
- R6: A take with `dec_ext` = N issues nothing, and raises no fault, until N+1 words are queued. Issue happens on the first clock edge at which they are present.
- R7: A flush empties the queue in one cycle, and tagged words removed by it never raise `exc_req`. The next instruction's `inst_pc` is the flush target.
- R8: Each flush toggles `cur_epoch`. A response whose `rsp_epoch` differs from `cur_epoch` is dropped and does not change `avail`.
- R9: `inst_commit` and `inst_abort` are never 1 together. An aborted instruction gives no commit, so it allows no write-back.
- R10: When `avail` equals the queue depth, `rsp_ready` = 0 and a presented response is not stored.
- R11: `inst_pc` starts at the reset or flush address and grows by 2 for every word consumed, whether the instruction was committed or aborted.
- R12: A flush in the same cycle as a take wins, and no instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsp_valid | input | 1 | Fetch response present |
| rsp_data | input | 16 | Fetched instruction word |
| rsp_err | input | 1 | Bus error on this fetch |
| rsp_epoch | input | 1 | Epoch the fetch was issued in |
| rsp_ready | output | 1 | Queue has room for a response |
| cur_epoch | output | 1 | Current flush epoch |
| flush | input | 1 | Change of flow from execute |
| flush_pc | input | AW | Opword address after the flush |
| peek_valid | output | 1 | Head word present |
| peek_word | output | 16 | Head word for decode |
| avail | output | $clog2(DEPTH+1) | Number of queued words |
| dec_take | input | 1 | Decode requests an instruction |
| dec_ext | input | $clog2(MAXEXT+1) | Extension words of that instruction |
| inst_valid | output | 1 | Instruction issued last cycle |
| inst_pc | output | AW | Opword address of issued instruction |
| inst_opword | output | 16 | Issued opword |
| inst_ext | output | 16*MAXEXT | Issued extension words, unused slots zero |
| inst_commit | output | 1 | Issued clean, write-back allowed |
| inst_abort | output | 1 | Issued with a tagged word, aborted |
| exc_req | output | 1 | Access-error request |
| exc_vector | output | 8 | Exception vector, 2 on a request |
| exc_addr | output | AW | Faulting opword address |

## Verification
The assertions assume that decode never asks for more than MAXEXT extension words. They also assume that no response from two flushes back is still in flight, because a one-bit epoch cannot tell that response from a current one. The stimulus keeps `dec_ext` between 0 and 2. It marks responses as stale only by giving them the opposite of the epoch the bench itself tracks, so a stale response always belongs to the generation just before the current one. Each response is offered for a single cycle whatever the value of `rsp_ready`, so refused words simply vanish, and the reference model drops them the same way.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned HW = 16;
  localparam logic [7:0] ACCESS_ERR_VEC = 8'd2;

  typedef struct packed {
    logic          err;
    logic [HW-1:0] data;
  } pfq_slot_t;

  // words occupied by an instruction with ext_cnt extension words
  function automatic int unsigned words_of(input int unsigned ext_cnt);
    return ext_cnt + 1;
  endfunction

  // byte address after consuming nwords halfwords
  function automatic logic [63:0] pc_after(input logic [63:0] pc, input int unsigned nwords);
    return pc + 64'(2 * nwords);
  endfunction

  // any of the first nwords error tags set
  function automatic logic any_tag(input logic [7:0] errs, input int unsigned nwords);
    logic hit;
    hit = 1'b0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < nwords && errs[i]) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/pfq_epoch.sv
module pfq_epoch (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic rsp_valid,
  input  logic rsp_epoch,
  input  logic room,
  output logic epoch,
  output logic accept,
  output logic stale
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     epoch <= 1'b0;
    else if (flush) epoch <= ~epoch;
  end

  assign stale  = rsp_valid && (rsp_epoch != epoch);
  assign accept = rsp_valid && !stale && room && !flush;
endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIN   = 3,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned WCW  = $clog2(WIN + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        push,
  input  pfq_pkg::pfq_slot_t          push_slot,
  input  logic [WCW-1:0]              pop_n,
  output pfq_pkg::pfq_slot_t [WIN-1:0] win,
  output logic [WIN-1:0]              win_vld,
  output logic [CW-1:0]               count,
  output logic                        full
);
  pfq_pkg::pfq_slot_t mem [DEPTH];
  logic [DEPTH-1:0]   vld;
  logic [PW-1:0]      rd_ptr;
  logic [PW-1:0]      wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      vld    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      for (int unsigned i = 0; i < WIN; i++) begin
        if (i < 32'(pop_n)) vld[rd_ptr + PW'(i)] <= 1'b0;
      end
      if (push) begin
        vld[wr_ptr] <= 1'b1;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      rd_ptr <= rd_ptr + PW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_slot;
  end

  for (genvar g = 0; g < WIN; g++) begin : g_win
    assign win[g]     = mem[rd_ptr + PW'(g)];
    assign win_vld[g] = vld[rd_ptr + PW'(g)];
  end

  assign count = CW'($countones(vld));
  assign full  = &vld;
endmodule

// File: rtl/pfq_issue.sv
module pfq_issue #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MAXEXT   = 2,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int unsigned WIN     = MAXEXT + 1,
  localparam int unsigned WCW     = $clog2(WIN + 1),
  localparam int unsigned EW      = $clog2(MAXEXT + 1),
  localparam int unsigned HW      = pfq_pkg::HW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [AW-1:0]                flush_pc,
  input  pfq_pkg::pfq_slot_t [WIN-1:0] win,
  input  logic [WIN-1:0]               win_vld,
  input  logic                         take,
  input  logic [EW-1:0]                ext_cnt,
  output logic [WCW-1:0]               pop_n,
  output logic                         fire,
  output logic                         hit,
  output logic                         inst_valid,
  output logic [AW-1:0]                inst_pc,
  output logic [HW-1:0]                inst_opword,
  output logic [HW*MAXEXT-1:0]         inst_ext,
  output logic                         inst_commit,
  output logic                         inst_abort
);
  logic [AW-1:0]  pc;
  logic [WIN-1:0] errs;
  logic           enough;
  int unsigned    need;
  logic [63:0]    adv;

  always_comb begin
    need   = pfq_pkg::words_of(32'(ext_cnt));
    enough = (need <= WIN);
    errs   = '0;
    for (int unsigned i = 0; i < WIN; i++) begin
      errs[i] = win[i].err;
      if (i < need && !win_vld[i]) enough = 1'b0;
    end
    fire  = take && enough && !flush;
    hit   = fire && pfq_pkg::any_tag(8'(errs), need);
    pop_n = fire ? WCW'(need) : '0;
    adv   = pfq_pkg::pc_after(64'(pc), need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc          <= RESET_PC;
      inst_valid  <= 1'b0;
      inst_commit <= 1'b0;
      inst_abort  <= 1'b0;
      inst_pc     <= '0;
      inst_opword <= '0;
      inst_ext    <= '0;
    end else if (flush) begin
      pc          <= flush_pc;
      inst_valid  <= 1'b0;
      inst_commit <= 1'b0;
      inst_abort  <= 1'b0;
    end else begin
      inst_valid  <= fire;
      inst_commit <= fire && !hit;
      inst_abort  <= hit;
      if (fire) begin
        inst_pc     <= pc;
        pc          <= adv[AW-1:0];
        inst_opword <= win[0].data;
        for (int unsigned i = 1; i < WIN; i++) begin
          inst_ext[(i-1)*HW +: HW] <= (i < need) ? win[i].data : '0;
        end
      end
    end
  end
endmodule

// File: rtl/pfq_deferred_fault.sv
module pfq_deferred_fault #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DEPTH    = 4,
  parameter int unsigned   MAXEXT   = 2,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int unsigned  WIN      = MAXEXT + 1,
  localparam int unsigned  CW       = $clog2(DEPTH + 1),
  localparam int unsigned  EW       = $clog2(MAXEXT + 1),
  localparam int unsigned  WCW      = $clog2(WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rsp_valid,
  input  logic [15:0]          rsp_data,
  input  logic                 rsp_err,
  input  logic                 rsp_epoch,
  output logic                 rsp_ready,
  output logic                 cur_epoch,
  input  logic                 flush,
  input  logic [AW-1:0]        flush_pc,
  output logic                 peek_valid,
  output logic [15:0]          peek_word,
  output logic [CW-1:0]        avail,
  input  logic                 dec_take,
  input  logic [EW-1:0]        dec_ext,
  output logic                 inst_valid,
  output logic [AW-1:0]        inst_pc,
  output logic [15:0]          inst_opword,
  output logic [16*MAXEXT-1:0] inst_ext,
  output logic                 inst_commit,
  output logic                 inst_abort,
  output logic                 exc_req,
  output logic [7:0]           exc_vector,
  output logic [AW-1:0]        exc_addr
);
  // named internal events
  logic                          accept_w;
  logic                          stale_w;
  logic                          fire_w;
  logic                          hit_w;
  logic                          full_w;
  logic [WCW-1:0]                pop_w;
  pfq_pkg::pfq_slot_t            in_slot;
  pfq_pkg::pfq_slot_t [WIN-1:0]  win_w;
  logic [WIN-1:0]                win_vld_w;

  assign in_slot = '{err: rsp_err, data: rsp_data};

  pfq_epoch u_epoch (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_epoch (rsp_epoch),
    .room      (!full_w),
    .epoch     (cur_epoch),
    .accept    (accept_w),
    .stale     (stale_w)
  );

  pfq_store #(.DEPTH(DEPTH), .WIN(WIN)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (accept_w),
    .push_slot (in_slot),
    .pop_n     (pop_w),
    .win       (win_w),
    .win_vld   (win_vld_w),
    .count     (avail),
    .full      (full_w)
  );

  pfq_issue #(.AW(AW), .MAXEXT(MAXEXT), .RESET_PC(RESET_PC)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .flush_pc    (flush_pc),
    .win         (win_w),
    .win_vld     (win_vld_w),
    .take        (dec_take),
    .ext_cnt     (dec_ext),
    .pop_n       (pop_w),
    .fire        (fire_w),
    .hit         (hit_w),
    .inst_valid  (inst_valid),
    .inst_pc     (inst_pc),
    .inst_opword (inst_opword),
    .inst_ext    (inst_ext),
    .inst_commit (inst_commit),
    .inst_abort  (inst_abort)
  );

  assign rsp_ready  = !full_w;
  assign peek_valid = win_vld_w[0];
  assign peek_word  = win_w[0].data;
  assign exc_req    = inst_abort;
  assign exc_vector = inst_abort ? pfq_pkg::ACCESS_ERR_VEC : 8'd0;
  assign exc_addr   = inst_pc;
endmodule

// File: rtl/pfq_deferred_fault_chk.sv
module pfq_deferred_fault_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3,
  parameter int unsigned EW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          dec_take,
  input logic [EW-1:0] dec_ext,
  input logic [CW-1:0] avail,
  input logic          rsp_ready,
  input logic          inst_valid,
  input logic          inst_commit,
  input logic          inst_abort,
  input logic          exc_req,
  input logic [7:0]    exc_vector,
  input logic [AW-1:0] exc_addr,
  input logic [AW-1:0] inst_pc,
  input logic          fire_w,
  input logic          accept_w,
  input logic          stale_w
);
  a_r9_commit_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(inst_commit && inst_abort));

  a_r4_exc_payload: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (inst_abort && exc_vector == 8'd2 && exc_addr == inst_pc));

  a_r3_exc_only_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(dec_take) && !$past(flush)));

  a_r6_words_present: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |-> (32'(avail) >= 32'(dec_ext) + 1));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (avail == '0 && !inst_valid && !exc_req));

  a_r8_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    stale_w |-> !accept_w);

  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(avail) == DEPTH) |-> (!rsp_ready && !accept_w));

  a_r12_flush_over_take: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fire_w);
endmodule

bind pfq_deferred_fault pfq_deferred_fault_chk #(
  .AW(AW), .DEPTH(DEPTH), .CW(CW), .EW(EW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .dec_take    (dec_take),
  .dec_ext     (dec_ext),
  .avail       (avail),
  .rsp_ready   (rsp_ready),
  .inst_valid  (inst_valid),
  .inst_commit (inst_commit),
  .inst_abort  (inst_abort),
  .exc_req     (exc_req),
  .exc_vector  (exc_vector),
  .exc_addr    (exc_addr),
  .inst_pc     (inst_pc),
  .fire_w      (fire_w),
  .accept_w    (accept_w),
  .stale_w     (stale_w)
);

// File: tb/pfq_deferred_fault_bench.sv
module pfq_deferred_fault_bench;
  localparam int AW = 32, DEPTH = 4, MAXEXT = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          rv, re, rep, fl, tk;
  logic [15:0]   rd;
  logic [AW-1:0] fpc;
  logic [1:0]    ext;
  logic          rsp_ready, cur_epoch, peek_valid, inst_valid, inst_commit, inst_abort, exc_req;
  logic [15:0]   peek_word, inst_opword;
  logic [2:0]    avail;
  logic [AW-1:0] inst_pc, exc_addr;
  logic [31:0]   inst_ext;
  logic [7:0]    exc_vector;

  pfq_deferred_fault u_pfq_deferred_fault (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rv), .rsp_data(rd), .rsp_err(re), .rsp_epoch(rep),
    .rsp_ready(rsp_ready), .cur_epoch(cur_epoch), .flush(fl), .flush_pc(fpc),
    .peek_valid(peek_valid), .peek_word(peek_word), .avail(avail), .dec_take(tk), .dec_ext(ext),
    .inst_valid(inst_valid), .inst_pc(inst_pc), .inst_opword(inst_opword), .inst_ext(inst_ext),
    .inst_commit(inst_commit), .inst_abort(inst_abort), .exc_req(exc_req),
    .exc_vector(exc_vector), .exc_addr(exc_addr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [15:0] mq_d[$];
  bit          mq_e[$];
  bit          m_epoch;
  logic [31:0] m_pc;
  bit          e_valid, e_commit, e_abort, last_fl, last_stale;
  logic [31:0] e_ipc;
  logic [15:0] e_op;
  logic [15:0] e_ext[MAXEXT];
  int          e_n;
  string       e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string atag;
    atag = last_fl ? "R7" : (last_stale ? "R8" : "R2");
    chk(rsp_ready == (mq_d.size() < DEPTH), "R10", "rsp_ready", 64'(rsp_ready), 64'(mq_d.size() < DEPTH));
    chk(32'(avail) == mq_d.size(), atag, "avail", 64'(avail), 64'(mq_d.size()));
    chk(cur_epoch == m_epoch, "R8", "cur_epoch", 64'(cur_epoch), 64'(m_epoch));
    chk(peek_valid == (mq_d.size() > 0), "R2", "peek_valid", 64'(peek_valid), 64'(mq_d.size() > 0));
    if (mq_d.size() > 0)
      chk(peek_word == mq_d[0], "R2", "peek_word", 64'(peek_word), 64'(mq_d[0]));
    chk(inst_valid == e_valid, e_tag, "inst_valid", 64'(inst_valid), 64'(e_valid));
    chk(exc_req == e_abort, e_tag, "exc_req", 64'(exc_req), 64'(e_abort));
    if (e_valid) begin
      chk(inst_pc == e_ipc, "R11", "inst_pc", 64'(inst_pc), 64'(e_ipc));
      chk(inst_opword == e_op, "R2", "inst_opword", 64'(inst_opword), 64'(e_op));
      chk(inst_commit == e_commit, "R9", "inst_commit", 64'(inst_commit), 64'(e_commit));
      chk(inst_abort == e_abort, e_tag, "inst_abort", 64'(inst_abort), 64'(e_abort));
      for (int k = 0; k < e_n - 1; k++)
        chk(inst_ext[k*16 +: 16] == e_ext[k], "R2", "inst_ext", 64'(inst_ext[k*16 +: 16]), 64'(e_ext[k]));
      if (e_abort) begin
        chk(exc_vector == 8'd2, e_tag, "exc_vector", 64'(exc_vector), 64'd2);
        chk(exc_addr == e_ipc, e_tag, "exc_addr", 64'(exc_addr), 64'(e_ipc));
      end
    end
  endtask

  task automatic step();
    int  sz, need;
    bit  ep, fault;
    @(posedge clk);
    sz = mq_d.size();
    ep = m_epoch;
    need = int'(ext) + 1;
    last_fl = fl;
    last_stale = rv && (rep != ep);
    if (fl) begin
      mq_d.delete(); mq_e.delete();
      m_epoch = ~m_epoch;
      m_pc = fpc;
      e_valid = 0; e_commit = 0; e_abort = 0;
      e_tag = tk ? "R12" : "R7";
    end else begin
      if (tk && sz >= need) begin
        fault = 0;
        for (int j = 0; j < need; j++) fault |= mq_e[j];
        e_valid = 1; e_ipc = m_pc; e_op = mq_d[0]; e_n = need;
        for (int j = 1; j < need; j++) e_ext[j-1] = mq_d[j];
        e_abort = fault; e_commit = !fault;
        e_tag = fault ? (mq_e[0] ? "R4" : "R5") : "R2";
        for (int j = 0; j < need; j++) begin
          void'(mq_d.pop_front()); void'(mq_e.pop_front());
        end
        m_pc = m_pc + 32'(2 * need);
      end else begin
        e_valid = 0; e_commit = 0; e_abort = 0;
        e_tag = tk ? "R6" : "R3";
      end
      if (rv && rep == ep && sz < DEPTH) begin
        mq_d.push_back(rd); mq_e.push_back(re);
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    rv = 0; rd = '0; re = 0; rep = m_epoch; fl = 0; fpc = '0; tk = 0; ext = '0;
  endtask

  task automatic resp(input logic [15:0] d, input bit e);
    rv = 1; rd = d; re = e; rep = m_epoch; step(); idle();
  endtask

  task automatic take(input int n);
    tk = 1; ext = 2'(n); step(); idle();
  endtask

  initial begin
    m_epoch = 0; m_pc = '0; e_valid = 0; e_commit = 0; e_abort = 0; e_n = 0;
    e_tag = "R1"; last_fl = 0; last_stale = 0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(avail == 3'd0 && !peek_valid, "R1", "empty", 64'(avail), 64'd0);
    chk(rsp_ready && !cur_epoch, "R1", "ready/epoch", 64'({rsp_ready, cur_epoch}), 64'b10);
    chk(!inst_valid && !inst_commit && !inst_abort && !exc_req, "R1", "issue outputs",
        64'({inst_valid, inst_commit, inst_abort, exc_req}), 64'd0);
    rst_n = 1;
    step();

    // R2: in-order delivery, clean instructions
    resp(16'h1111, 0); resp(16'h2222, 0); resp(16'h3333, 0);
    take(0); take(1);
    // R3/R4: tagged opword, reported only on take
    resp(16'hA001, 1); step();
    take(0);
    // R5: tagged extension word
    resp(16'hB001, 0); resp(16'hB002, 1);
    take(1);
    // R6: take held until all three words are present
    tk = 1; ext = 2'd2; step(); step();
    rv = 1; rd = 16'hC001; re = 0; rep = m_epoch; step();
    rd = 16'hC002; step();
    rd = 16'hC003; step();
    rv = 0; step(); step();
    idle();
    // R7: tagged words flushed never fault
    resp(16'hD001, 1); resp(16'hD002, 1);
    fl = 1; fpc = 32'h0000_0100; step(); idle();
    take(0); take(0); step();
    // R8: stale response dropped
    rv = 1; rd = 16'hE0E0; re = 1; rep = ~m_epoch; step(); idle();
    resp(16'hE001, 0); take(0);
    // R10: overfill
    resp(16'hF001, 0); resp(16'hF002, 1); resp(16'hF003, 0); resp(16'hF004, 0); resp(16'hF005, 0);
    // R12: flush and take together
    fl = 1; fpc = 32'h0000_2000; tk = 1; ext = 2'd0; step(); idle();
    resp(16'h7001, 0); take(0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      rv  = 1'($urandom % 2);
      rd  = 16'($urandom);
      re  = ($urandom % 5) == 0;
      rep = (($urandom % 8) == 0) ? ~m_epoch : m_epoch;
      fl  = ($urandom % 25) == 0;
      fpc = {16'($urandom), 15'($urandom), 1'b0};
      tk  = 1'($urandom % 2);
      ext = 2'($urandom % 3);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule